// File: doc/BRIEF.md
# Circular Page-Write Staging Buffer

This block gathers the data bytes of one write transaction before they are committed to nonvolatile storage. A start strobe opens a transaction and latches a base offset inside a 16-byte page. Each data strobe then stores one byte. If the transaction carries more than 16 bytes, the oldest stored byte is replaced first, so the buffer always holds the most recent sixteen.

A stop strobe commits the transaction. The block then presents the kept bytes to a memory write port, one per clock and oldest first, each with its page offset. After that it holds a busy flag for a programmable number of clocks, which models the programming time of the array. While the block is busy, every strobe is ignored. A data strobe that arrives in that window also sets a sticky error flag. A transaction that carried no data bytes starts neither a replay nor a busy interval.

Top module: `page_stage_buf`

## Requirements
- R1: After reset, `busy`, `mem_we` and `drop_err` are 0.
- R2: A `txn_start` accepted while not busy opens a transaction. Each `byte_valid` then stores one byte, unless it arrives together with `txn_start` or `txn_stop`. Of N stored bytes, the last min(N,16) are kept.
- R3: When a stop is accepted with at least one byte kept, `mem_we` is high on each of the next min(N,16) clocks. The bytes appear oldest first, one per clock, with no gap.
- R4: The byte with index k (counting from 0) in a transaction is written to offset (B + k) mod 16, where B is the `base_off` value sampled with the accepted `txn_start`.
- R5: `busy` rises on the clock after an accepted stop. It stays high for exactly min(N,16) + WRITE_CYCLES clocks. `mem_we` is never high unless `busy` is high.
- R6: A stop accepted with no bytes stored closes the transaction. It produces no `mem_we` pulse and no `busy`.
- R7: While `busy` is high, `txn_start`, `byte_valid` and `txn_stop` have no effect on the stored data or on the writes. A `byte_valid` in that window sets `drop_err`, which stays 1 until reset.
- R8: A `byte_valid` or `txn_stop` that arrives while no transaction is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Strobe that opens a transaction |
| base_off | input | 4 | Page offset of the first byte, sampled with the start strobe |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| txn_stop | input | 1 | Strobe that ends and commits the transaction |
| mem_we | output | 1 | Write enable of the memory port |
| mem_off | output | 4 | Page offset of the byte being written |
| mem_data | output | 8 | Byte being written |
| busy | output | 1 | High during replay and the timed write cycle |
| drop_err | output | 1 | Sticky flag: a data strobe arrived while busy |

## Verification
The bench builds the block with its default 16-byte page and 8-bit data, but shortens WRITE_CYCLES to 7 clocks so that every write cycle fits in a short run. It sweeps every transaction length from 0 to 20 bytes and rotates the base offset across all 16 positions. This covers the empty case, partly filled pages, the exact fill at 16, and overwrite depths of 1 to 4 with offset wraparound. Separate sequences send strobes during a busy interval and outside any open transaction.

// File: rtl/psb_pkg.sv
`timescale 1ns/1ps
package psb_pkg;
  // Saturating occupancy increment
  function automatic int sat_inc(input int cnt, input int depth);
    return (cnt >= depth) ? depth : cnt + 1;
  endfunction

  // Slot holding the oldest kept byte
  function automatic int first_slot(input int cnt, input int wptr, input int depth);
    return (cnt >= depth) ? wptr : 0;
  endfunction

  // Page offset of the byte stored in a slot
  function automatic int slot_off(input int base, input int slot, input int depth);
    return (base + slot) % depth;
  endfunction
endpackage

// File: rtl/psb_store.sv
`timescale 1ns/1ps
module psb_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_start,
  input  logic [AW-1:0] base_off,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_data,
  input  logic          txn_stop,
  input  logic          busy,
  input  logic [AW-1:0] rd_slot,
  output logic [DW-1:0] rd_data,
  output logic          commit_go,
  output logic [CW-1:0] commit_len,
  output logic [AW-1:0] commit_first,
  output logic [AW-1:0] base_q,
  output logic          drop_err
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [CW-1:0] count;
  logic          open_q;

  // Named events for the assertions
  logic take_start, take_byte, take_stop, drop_evt, empty_stop;
  assign take_start = txn_start && !busy;
  assign take_stop  = txn_stop && open_q && !busy && !txn_start;
  assign take_byte  = byte_valid && open_q && !busy && !txn_start && !txn_stop;
  assign drop_evt   = byte_valid && busy;
  assign commit_go  = take_stop && (count != '0);
  assign empty_stop = take_stop && (count == '0);

  assign commit_len   = count;
  assign commit_first = AW'(psb_pkg::first_slot(int'(count), int'(wptr), DEPTH));
  assign rd_data      = mem[rd_slot];

  always_ff @(posedge clk) begin
    if (take_byte) mem[wptr] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      count    <= '0;
      open_q   <= 1'b0;
      base_q   <= '0;
      drop_err <= 1'b0;
    end else begin
      if (drop_evt) drop_err <= 1'b1;
      if (take_start) begin
        open_q <= 1'b1;
        wptr   <= '0;
        count  <= '0;
        base_q <= base_off;
      end else if (take_stop) begin
        open_q <= 1'b0;
      end else if (take_byte) begin
        wptr  <= wptr + 1'b1;
        count <= CW'(psb_pkg::sat_inc(int'(count), DEPTH));
      end
    end
  end

  a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && count < CW'(DEPTH)) |=> count == $past(count) + 1'b1);
  a_r6_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_stop && !busy) |=> !busy);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> drop_err);
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (count == $past(count)) && (base_q == $past(base_q)));
  a_r8_closed_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !txn_start) |=> (count == $past(count)) && !open_q);
endmodule

// File: rtl/psb_seq.sv
`timescale 1ns/1ps
module psb_seq #(
  parameter int DEPTH        = 16,
  parameter int DW           = 8,
  parameter int WRITE_CYCLES = 500000,
  localparam int AW          = $clog2(DEPTH),
  localparam int CW          = AW + 1,
  localparam int TW          = $clog2(WRITE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_go,
  input  logic [CW-1:0] commit_len,
  input  logic [AW-1:0] commit_first,
  input  logic [AW-1:0] base_q,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_slot,
  output logic          mem_we,
  output logic [AW-1:0] mem_off,
  output logic [DW-1:0] mem_data,
  output logic          busy
);
  typedef enum logic [1:0] {PH_IDLE, PH_PLAY, PH_HOLD} phase_t;
  phase_t        phase;
  logic [AW-1:0] slot;
  logic [CW-1:0] left;
  logic [TW-1:0] timer;

  logic play_last, hold_done;
  assign play_last = (phase == PH_PLAY) && (left == CW'(1));
  assign hold_done = (phase == PH_HOLD) && (timer == TW'(WRITE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      slot  <= '0;
      left  <= '0;
      timer <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (commit_go) begin
          phase <= PH_PLAY;
          slot  <= commit_first;
          left  <= commit_len;
        end
        PH_PLAY: begin
          slot <= slot + 1'b1;
          left <= left - 1'b1;
          if (play_last) begin
            phase <= PH_HOLD;
            timer <= '0;
          end
        end
        PH_HOLD: begin
          if (hold_done) phase <= PH_IDLE;
          else timer <= timer + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign rd_slot  = slot;
  assign mem_we   = (phase == PH_PLAY);
  assign mem_data = rd_data;
  assign mem_off  = AW'(psb_pkg::slot_off(int'(base_q), int'(slot), DEPTH));
  assign busy     = (phase != PH_IDLE);

  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !play_last) |=> mem_we && (mem_off == $past(mem_off) + 1'b1));
  a_r3_start_next: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && commit_go) |=> mem_we);
  a_r5_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> timer < TW'(WRITE_CYCLES));
  a_r5_hold_after_play: assert property (@(posedge clk) disable iff (!rst_n)
    play_last |=> busy && !mem_we);
endmodule

// File: rtl/page_stage_buf.sv
`timescale 1ns/1ps
module page_stage_buf #(
  parameter int DEPTH        = 16,
  parameter int DW           = 8,
  parameter int WRITE_CYCLES = 500000,
  localparam int AW          = $clog2(DEPTH),
  localparam int CW          = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_start,
  input  logic [AW-1:0] base_off,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_data,
  input  logic          txn_stop,
  output logic          mem_we,
  output logic [AW-1:0] mem_off,
  output logic [DW-1:0] mem_data,
  output logic          busy,
  output logic          drop_err
);
  logic          commit_go;
  logic [CW-1:0] commit_len;
  logic [AW-1:0] commit_first, base_q, rd_slot;
  logic [DW-1:0] rd_data;

  psb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk, .rst_n, .txn_start, .base_off, .byte_valid, .byte_data, .txn_stop,
    .busy, .rd_slot, .rd_data, .commit_go, .commit_len, .commit_first,
    .base_q, .drop_err
  );

  psb_seq #(.DEPTH(DEPTH), .DW(DW), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk, .rst_n, .commit_go, .commit_len, .commit_first, .base_q, .rd_data,
    .rd_slot, .mem_we, .mem_off, .mem_data, .busy
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !busy && !mem_we && !drop_err);
endmodule

// File: tb/page_stage_buf_test.sv
`timescale 1ns/1ps
module page_stage_buf_test;
  localparam int WC = 7;
  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 0, byte_valid = 0, txn_stop = 0;
  logic [3:0] base_off = '0;
  logic [7:0] byte_data = '0;
  logic mem_we, busy, drop_err;
  logic [3:0] mem_off;
  logic [7:0] mem_data;

  page_stage_buf #(.WRITE_CYCLES(WC)) uut (
    .clk, .rst_n, .txn_start, .base_off, .byte_valid, .byte_data, .txn_stop,
    .mem_we, .mem_off, .mem_data, .busy, .drop_err
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int log_n = 0, busy_n = 0;
  logic [3:0] log_off [64];
  logic [7:0] log_dat [64];

  always @(negedge clk) begin
    if (mem_we && log_n < 64) begin
      log_off[log_n] = mem_off;
      log_dat[log_n] = mem_data;
      log_n++;
    end
    if (busy) busy_n++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int n, input int k);
    return 8'((n * 37 + k * 11 + 3) & 255);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Open, send n bytes, optionally stop
  task automatic send(input int n, input int base, input bit stop);
    txn_start = 1; base_off = 4'(base); tick(); txn_start = 0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1; byte_data = pat(n, k); tick();
    end
    byte_valid = 0;
    if (stop) begin txn_stop = 1; tick(); txn_stop = 0; end
  endtask

  task automatic settle();
    repeat (24 + WC) @(posedge clk);
    #1;
  endtask

  task automatic verify(input int n, input int base);
    int kept = (n > 16) ? 16 : n;
    int first = n - kept;
    check("R3 write count", log_n, kept);
    check("R5 busy length", busy_n, (kept > 0) ? kept + WC : 0);
    for (int i = 0; i < kept && i < log_n; i++) begin
      check("R4 offset", int'(log_off[i]), (base + first + i) % 16);
      check("R2 data", int'(log_dat[i]), int'(pat(n, first + i)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 mem_we", int'(mem_we), 0);
    check("R1 drop_err", int'(drop_err), 0);
    rst_n = 1; tick();

    // Sweep lengths 0..20, rotating base offsets (R2 R3 R4 R5 R6)
    for (int n = 0; n <= 20; n++) begin
      int base = (n * 5 + 3) % 16;
      log_n = 0; busy_n = 0;
      send(n, base, 1);
      @(negedge clk);
      check("R3 first write next clock", int'(mem_we), (n > 0) ? 1 : 0);
      check("R6 busy only if data", int'(busy), (n > 0) ? 1 : 0);
      settle();
      verify(n, base);
    end
    check("R7 no error yet", int'(drop_err), 0);

    // Strobes while busy (R7)
    log_n = 0; busy_n = 0;
    send(3, 9, 1);
    send(2, 1, 1);
    settle();
    verify(3, 9);
    check("R7 drop_err set", int'(drop_err), 1);

    // Strobes with no open transaction (R8)
    log_n = 0; busy_n = 0;
    byte_valid = 1; byte_data = 8'hA5; tick(); byte_valid = 0;
    txn_stop = 1; tick(); txn_stop = 0;
    settle();
    check("R8 no writes when closed", log_n, 0);
    check("R8 no busy when closed", busy_n, 0);

    // Normal transaction after error: flag stays (R7), data intact (R2)
    log_n = 0; busy_n = 0;
    send(5, 14, 1);
    settle();
    verify(5, 14);
    check("R7 drop_err sticky", int'(drop_err), 1);

    // Reset clears the sticky flag (R1)
    rst_n = 0; tick();
    @(negedge clk);
    check("R1 flag cleared by reset", int'(drop_err), 0);
    finish_run();
  end
endmodule